// File: doc/BRIEF.md
# Transmit Read-Request Threshold Gate

This block decides when a transmit staging buffer asks the packet buffer for a read. A request opens with a start strobe that carries its length in 16-byte lines. Each line that lands in the staging buffer is reported with a one-cycle strobe. The block counts these lines and issues a single one-cycle read command once enough of the request has arrived.

The amount needed is picked by a 2-bit fill code. Three of the codes name a fixed line count. The fourth code turns off the count limit, so the command waits until the whole request is buffered. A request that ends early still gets its command: this happens when the line count reaches the request length, or when the request is closed by a completion strobe before the threshold was met.

The fill code and the length are captured when the request starts. Changing the code partway through a request has no effect until the next request begins.

Top module: `rd_threshold_gate`

## Requirements
- R1: After reset `readCmd` is low, and while no request is open, neither `lineValid` nor `reqDone` raises it.
- R2: With fill code 2'b00 captured, the command fires after the 2nd line of a request whose length is at least 2.
- R3: With fill code 2'b01 captured, the command fires after the 4th line of a request whose length is at least 4.
- R4: With fill code 2'b10 captured, the command fires after the 8th line of a request whose length is at least 8.
- R5: With fill code 2'b11 captured, the command fires after the line whose arrival brings the count up to the request length.
- R6: For codes 2'b00 to 2'b10, a request shorter than the selected threshold fires on the line that brings the count up to its length.
- R7: If `reqDone` arrives before the command has fired (this includes a request of length 0), the command fires in the next cycle. A `reqDone` that comes after the command has fired produces no second pulse.
- R8: At most one command pulse is issued per request. Lines that arrive after the trigger, or beyond the request length, produce no further pulse.
- R9: The line count clears at `reqStart`. A line strobe in the same cycle as `reqStart` is not counted. A new `reqStart` abandons an open request without issuing a command for it.
- R10: `thrCode` is sampled only in the `reqStart` cycle. Changing it during a request does not move that request's trigger point.
- R11: `readCmd` is high for exactly one cycle, namely the cycle after the clock edge that samples the triggering line or the triggering `reqDone`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| thrCode | input | 2 | Fill code: 00 = 2 lines, 01 = 4 lines, 10 = 8 lines, 11 = whole request |
| reqStart | input | 1 | Opens a new request (one-cycle strobe) |
| reqLines | input | LEN_W (8) | Request length in 16-byte lines, sampled with `reqStart` |
| lineValid | input | 1 | One line has arrived in the staging buffer |
| reqDone | input | 1 | Request-complete indication |
| readCmd | output | 1 | One-cycle read command toward the packet buffer |

## Verification
The bench sweeps every fill code against request lengths from 0 through 10. It covers the normal case, a line strobe coincident with the start, and an early completion. A design that compares against the wrong threshold, or uses the code it sees mid-request instead of the captured one, fires at the wrong line index. A design that fails to saturate at the request length, or that ignores short requests, either never fires or fires twice. One abandoned request and strobes sent while idle check that stale counts and idle completion strobes raise no command.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  typedef struct packed {
    logic capture;  // latch code and length, clear count
    logic incr;     // count one arriving line
  } rtgStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SENT = 2'd2
  } rtgState_t;

  // Fixed line thresholds for codes 00..10; code 11 handled separately.
  function automatic int unsigned codeToLines(input logic [1:0] code);
    case (code)
      2'b00:   return 2;
      2'b01:   return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtgStrobe_t       strobe,
  input  logic [1:0]       thrCode,
  input  logic [LEN_W-1:0] reqLines,
  output logic             lineHit
);

  localparam logic [1:0] DEFAULT_CODE = 2'b01;

  logic [1:0]       codeQ;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] countQ;
  logic [LEN_W-1:0] target;
  logic [LEN_W-1:0] fixedThr;
  logic [LEN_W-1:0] countNext;
  logic             incrOk;

  always_comb begin
    fixedThr = LEN_W'(codeToLines(codeQ));
    if (codeQ == 2'b11) begin
      target = lenQ;
    end else if (lenQ < fixedThr) begin
      target = lenQ;
    end else begin
      target = fixedThr;
    end
    incrOk    = (countQ < lenQ);
    countNext = countQ + LEN_W'(1);
    lineHit   = incrOk && (countNext == target);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ  <= DEFAULT_CODE;
      lenQ   <= '0;
      countQ <= '0;
    end else if (strobe.capture) begin
      codeQ  <= thrCode;
      lenQ   <= reqLines;
      countQ <= '0;
    end else if (strobe.incr && incrOk) begin
      countQ <= countNext;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= lenQ);  // R8

  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> countQ == '0);  // R9

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !strobe.incr) |=> $stable(countQ));  // R9

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(codeQ));  // R10

endmodule

// File: rtl/rtg_control.sv
module rtg_control
  import rtg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       lineValid,
  input  logic       reqDone,
  input  logic       lineHit,
  output rtgStrobe_t strobe,
  output logic       readCmd
);

  rtgState_t stateQ, stateD;
  logic      fire;
  logic      readCmdQ;

  always_comb begin
    stateD         = stateQ;
    fire           = 1'b0;
    strobe.capture = reqStart;
    strobe.incr    = lineValid && !reqStart && (stateQ != ST_IDLE);
    if (reqStart) begin
      stateD = ST_FILL;
    end else begin
      case (stateQ)
        ST_FILL: begin
          if (lineValid && lineHit) begin
            fire   = 1'b1;
            stateD = reqDone ? ST_IDLE : ST_SENT;
          end else if (reqDone) begin
            fire   = 1'b1;
            stateD = ST_IDLE;
          end
        end
        ST_SENT: begin
          if (reqDone) stateD = ST_IDLE;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      readCmdQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      readCmdQ <= fire;
    end
  end

  assign readCmd = readCmdQ;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    readCmd |=> !readCmd);  // R11

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SENT && !reqStart) |=> !readCmd);  // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !reqStart) |=> !readCmd);  // R1

  AST_SENT_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (readCmd && !$past(reqDone) && !$past(reqStart)) |-> stateQ != ST_FILL);  // R8

endmodule

// File: rtl/rd_threshold_gate.sv
module rd_threshold_gate
  import rtg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       thrCode,
  input  logic             reqStart,
  input  logic [LEN_W-1:0] reqLines,
  input  logic             lineValid,
  input  logic             reqDone,
  output logic             readCmd
);

  rtgStrobe_t strobe;
  logic       lineHit;

  rtg_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqStart  (reqStart),
    .lineValid (lineValid),
    .reqDone   (reqDone),
    .lineHit   (lineHit),
    .strobe    (strobe),
    .readCmd   (readCmd)
  );

  rtg_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .thrCode  (thrCode),
    .reqLines (reqLines),
    .lineHit  (lineHit)
  );

endmodule

// File: tb/tb_rd_threshold_gate.sv
module tb_rd_threshold_gate;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       thrCode = 2'b00;
  logic             reqStart = 1'b0;
  logic [LEN_W-1:0] reqLines = '0;
  logic             lineValid = 1'b0;
  logic             reqDone = 1'b0;
  logic             readCmd;

  int vecCount = 0;
  int errCount = 0;

  always #10 clk = ~clk;  // 50 MHz

  rd_threshold_gate #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .thrCode(thrCode), .reqStart(reqStart),
    .reqLines(reqLines), .lineValid(lineValid), .reqDone(reqDone),
    .readCmd(readCmd)
  );

  task automatic check(input logic exp, input string req);
    vecCount++;
    if (readCmd !== exp) begin
      errCount++;
      $display("FAIL %s: readCmd=%0b expected %0b at %0t", req, readCmd, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, then look at readCmd one edge later.
  task automatic step(input logic st, input logic ln, input logic dn);
    reqStart  = st;
    lineValid = ln;
    reqDone   = dn;
    @(negedge clk);
    reqStart  = 1'b0;
    lineValid = 1'b0;
    reqDone   = 1'b0;
  endtask

  function automatic int expTarget(input int code, input int len);
    int thr;
    thr = (code == 0) ? 2 : (code == 1) ? 4 : 8;
    if (code == 3 || len < thr) return len;
    return thr;
  endfunction

  function automatic string reqTag(input int code, input int len);
    if (code == 3) return "R5";
    if (len < ((code == 0) ? 2 : (code == 1) ? 4 : 8)) return "R6";
    return (code == 0) ? "R2" : (code == 1) ? "R3" : "R4";
  endfunction

  // variant 0: normal, 1: line coincident with start, 2: early completion
  task automatic runReq(input int code, input int len, input int variant);
    int tgt;
    int nLines;
    tgt = expTarget(code, len);
    thrCode  = 2'(code);
    reqLines = LEN_W'(len);
    step(1'b1, variant == 1, 1'b0);
    check(1'b0, "R9");
    thrCode = 2'(code ^ 1);  // R10: mid-request change must not matter
    if (variant == 2 && len > 0) begin
      for (int n = 1; n < tgt; n++) begin
        step(1'b0, 1'b1, 1'b0);
        check(1'b0, "R10");
      end
      step(1'b0, 1'b0, 1'b1);
      check(1'b1, "R7");
      @(negedge clk);
      check(1'b0, "R11");
    end else begin
      nLines = len + 2;
      for (int n = 1; n <= nLines; n++) begin
        step(1'b0, 1'b1, 1'b0);
        check((len > 0 && n == tgt) ? 1'b1 : 1'b0, (n == tgt) ? reqTag(code, len) : "R8");
        if (n[0]) begin
          @(negedge clk);
          check(1'b0, "R11");
        end
      end
      step(1'b0, 1'b0, 1'b1);
      check((len == 0) ? 1'b1 : 1'b0, "R7");
      @(negedge clk);
      check(1'b0, "R8");
    end
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    errCount++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    check(1'b0, "R1");
    step(1'b0, 1'b1, 1'b0);
    check(1'b0, "R1");
    step(1'b0, 1'b0, 1'b1);
    check(1'b0, "R1");

    // Abandoned request: 3 of 8 lines under code 01, then restart.
    thrCode  = 2'b01;
    reqLines = 8'd8;
    step(1'b1, 1'b0, 1'b0);
    for (int n = 0; n < 3; n++) begin
      step(1'b0, 1'b1, 1'b0);
      check(1'b0, "R9");
    end
    step(1'b1, 1'b0, 1'b0);
    check(1'b0, "R9");
    for (int n = 1; n <= 4; n++) begin
      step(1'b0, 1'b1, 1'b0);
      check((n == 4) ? 1'b1 : 1'b0, "R9");
    end
    step(1'b0, 1'b0, 1'b1);
    check(1'b0, "R7");

    for (int code = 0; code < 4; code++)
      for (int len = 0; len <= 10; len++)
        for (int v = 0; v < 3; v++)
          runReq(code, len, v);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule